// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs single clause-22 management transactions toward an Ethernet PHY. A host writes one 32-bit command word. The word carries the operation, the PHY and register addresses, and the data for a write. The engine then clocks a full management frame out on MDC and MDIO.

The same word is read back as status. A ready bit drops when a command is accepted and rises when the frame ends. After a read completes, the low half holds the 16 bits the PHY returned. The host polls the ready bit. While a frame is in flight, new commands are dropped. A command that asks for both operations, or for neither, finishes at once without touching the bus.

MDC is divided down from the system clock. Each MDC phase lasts `MDC_HALF` system cycles. The default of 40 gives 2.5 MHz from a 200 MHz clock.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, status_o reads 32'h1000_0000 (ready set, all other fields zero), MDC is low and MDIO is not driven.
- R2: Command word fields: bit 27 requests a read, bit 26 requests a write, bits 25:21 hold the PHY address, bits 20:16 hold the register number, and bits 15:0 hold the write data. Writing a valid command while idle clears ready (status bit 28) in the next cycle and echoes bits 27:16 in the status word.
- R3: The frame is 64 bits, each shifted MSB first: 32 ones, start 01, opcode (10 for read, 01 for write), 5-bit PHY address, 5-bit register number, 2 turnaround bits, then 16 data bits. On a write the turnaround is 10.
- R4: The engine changes MDIO only while MDC is low, so the value on MDIO is stable during every MDC high phase.
- R5: MDC high and low phases each last MDC_HALF system cycles during a frame, and MDC stays low while the engine is idle.
- R6: On a read, the engine stops driving MDIO for the two turnaround bits and the 16 data bits. It samples MDIO on each rising MDC edge of the data bits, MSB first, and places the result in status bits 15:0.
- R7: Ready rises exactly 128*MDC_HALF cycles after the accepting clock edge. With the default settings, this is well under 64 us.
- R8: A command written while a frame is in progress is ignored. The status fields and the frame on the wire stay those of the running command.
- R9: A command with both opcode bits set or both clear produces no MDC activity and leaves ready set. Its fields are still echoed in the status word.
- R10: After a write completes, status bits 15:0 hold the data that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Write strobe for the command word |
| cmd_wdata_i | input | 32 | Command word |
| status_o | output | 32 | Ready bit, echoed command fields and data |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven by the engine |
| mdio_oe_o | output | 1 | High while the engine drives MDIO |
| mdio_i | input | 1 | Management data seen on the wire |

## Verification
The assertions assume the host raises the write strobe for exactly one cycle per command. They also assume mdio_i holds a defined level whenever the engine samples it. The bench meets both assumptions as follows. Its tasks pulse the strobe for a single cycle between falling clock edges. A PHY model sets a new data level on each falling MDC edge, and it pulls the line high everywhere else. Commands that arrive while a frame is in flight are placed mid-frame on purpose, so the drop path runs with a known frame on the wire.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_IDX     = 46;  // first turnaround bit
  localparam int DATA_IDX   = 48;  // first data bit

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] data;
  } mdio_cmd_t;

  function automatic mdio_cmd_t unpack_cmd(input logic [31:0] w);
    return mdio_cmd_t'(w[27:0]);
  endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int MDC_HALF = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (MDC_HALF > 2) ? $clog2(MDC_HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          last;

  assign last = (cnt_q == CW'(MDC_HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (last) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = run_i & last & ~mdc_q;
  assign fall_o = run_i & last & mdc_q;

  // MDC high phase is held until the divider wraps
  assert_mdc_phase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && mdc_q && !last) |=> mdc_q);
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_mgmt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        is_rd_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] wdata_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rd_data_o,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic                  busy_q, rd_q;
  logic [5:0]            idx_q;
  logic [FRAME_BITS-1:0] sreg_q;
  logic [15:0]           rsh_q;
  logic                  last_bit;

  assign last_bit = (idx_q == 6'(FRAME_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      sreg_q <= '0;
      rsh_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      rd_q   <= is_rd_i;
      idx_q  <= '0;
      sreg_q <= {32'hFFFF_FFFF, 2'b01, is_rd_i ? 2'b10 : 2'b01, phy_i, reg_i,
                 is_rd_i ? 2'b11 : 2'b10, is_rd_i ? 16'hFFFF : wdata_i};
    end else if (busy_q) begin
      if (rise_i && rd_q && idx_q >= 6'(DATA_IDX))
        rsh_q <= {rsh_q[14:0], mdio_i};
      if (fall_i) begin
        if (last_bit) begin
          busy_q <= 1'b0;
        end else begin
          idx_q  <= idx_q + 1'b1;
          sreg_q <= {sreg_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = busy_q & fall_i & last_bit;
  assign rd_data_o = rsh_q;
  assign mdio_o    = sreg_q[FRAME_BITS-1];
  assign mdio_oe_o = busy_q & ~(rd_q & (idx_q >= 6'(TA_IDX)));

  // Output bit only moves on a falling MDC event
  assert_mdio_change_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && !$past(fall_i)) |-> $stable(mdio_o));
  assert_single_event_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_i && fall_i));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_HALF = 40
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [31:0] cmd_wdata_i,
  output logic [31:0] status_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam int FRAME_CYC = 2 * FRAME_BITS * MDC_HALF;
  localparam int BW        = $clog2(FRAME_CYC + 2);

  mdio_cmd_t   cw, cmd_q;
  logic        ready_q, busy, done, accept, valid_op, start;
  logic        rise, fall;
  logic [15:0] rd_data;
  logic        unused_hi;

  assign unused_hi = ^cmd_wdata_i[31:28];
  assign cw        = unpack_cmd(cmd_wdata_i);
  assign valid_op  = cw.rd ^ cw.wr;
  assign accept    = cmd_we_i & ~busy;
  assign start     = accept & valid_op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b1;
      cmd_q   <= '0;
    end else if (accept) begin
      cmd_q   <= cw;
      ready_q <= ~valid_op;
    end else if (done) begin
      ready_q <= 1'b1;
      if (cmd_q.rd) cmd_q.data <= rd_data;
    end
  end

  assign status_o = {3'b000, ready_q, cmd_q};

  mdio_clk_gen #(.MDC_HALF(MDC_HALF)) clk_gen_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_shifter shifter_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .is_rd_i   (cw.rd),
    .phy_i     (cw.phy),
    .reg_i     (cw.regad),
    .wdata_i   (cw.data),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .done_o    (done),
    .rd_data_o (rd_data),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );

  // Busy-cycle counter bounds the frame length
  logic [BW-1:0] busy_cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   busy_cyc_q <= '0;
    else if (busy) busy_cyc_q <= busy_cyc_q + 1'b1;
    else           busy_cyc_q <= '0;
  end

  assert_frame_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cyc_q <= BW'(FRAME_CYC));
  assert_ready_vs_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q != busy);
  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |-> (!mdc_o && !mdio_oe_o));
  assert_start_clears_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && ready_q && valid_op) |=> !status_o[28]);
  assert_busy_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && busy) |=> $stable(status_o[27:16]));
  assert_invalid_op_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && ready_q && !valid_op) |=> (status_o[28] && !mdc_o));
endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb_top;
  localparam int HALF = 40;
  localparam int FRAME_CYC = 128 * HALF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] status;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_drv = 1'b1;
  logic [15:0] phy_data = '0;

  int checks = 0, errors = 0;
  int rises = 0, oe_rises = 0, glitches = 0, bad_phase = 0, phase_len = 0;
  logic [63:0] cap = '0;
  logic prev_mdc = 1'b0, prev_o = 1'b0;
  bit   finished = 0;

  always #2.5 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : phy_drv;

  mdio_mgmt_ctrl #(.MDC_HALF(HALF)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata),
    .status_o(status), .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe),
    .mdio_i(mdio_i)
  );

  always @(posedge mdc) begin
    cap = {cap[62:0], mdio_i};
    rises = rises + 1;
    if (mdio_oe) oe_rises = oe_rises + 1;
  end

  always @(negedge mdc) begin
    if (rises >= 48 && rises < 64) phy_drv = phy_data[15 - (rises - 48)];
    else phy_drv = 1'b1;
  end

  always @(negedge clk) begin
    if (mdc && prev_mdc && mdio_oe && mdio_o != prev_o) glitches = glitches + 1;
    if (mdc != prev_mdc) begin
      if (!mdc && phase_len != HALF) bad_phase = bad_phase + 1;
      phase_len = 1;
    end else begin
      phase_len = phase_len + 1;
    end
    prev_mdc = mdc;
    prev_o = mdio_o;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit rd, input bit wr, input logic [4:0] phy,
                                     input logic [4:0] rg, input logic [15:0] d);
    return {4'b0, rd, wr, phy, rg, d};
  endfunction

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!status[28] && n < 3 * FRAME_CYC) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset;
    chk(status == 32'h1000_0000, "R1 status", status, 32'h1000_0000);
    chk(!mdc && !mdio_oe, "R1 bus idle", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    int n;
    logic [63:0] exp;
    rises = 0; oe_rises = 0; glitches = 0; bad_phase = 0;
    issue(mk(0, 1, phy, rg, d));
    chk(!status[28], "R2 ready cleared", status, 0);
    chk(status[27:16] == {2'b01, phy, rg}, "R2 fields echoed", status[27:16], {2'b01, phy, rg});
    wait_ready(n);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, d};
    chk(n == FRAME_CYC, "R7 frame duration", n, FRAME_CYC);
    chk(rises == 64 && cap == exp, "R3 write frame", cap, exp);
    chk(oe_rises == 64, "R3 driven all bits", oe_rises, 64);
    chk(glitches == 0, "R4 stable while MDC high", glitches, 0);
    chk(bad_phase == 0, "R5 MDC phase length", bad_phase, 0);
    chk(status == {4'b0001, 2'b01, phy, rg, d}, "R10 write status", status, {4'b0001, 2'b01, phy, rg, d});
    chk(!mdc, "R5 MDC low when idle", mdc, 0);
  endtask

  task automatic t_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    int n;
    logic [45:0] exph;
    rises = 0; oe_rises = 0; glitches = 0;
    phy_data = d;
    issue(mk(1, 0, phy, rg, 16'h0));
    chk(!status[28], "R2 ready cleared on read", status, 0);
    wait_ready(n);
    exph = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg};
    chk(n == FRAME_CYC, "R7 read duration", n, FRAME_CYC);
    chk(cap[63:18] == exph, "R3 read header", cap[63:18], exph);
    chk(oe_rises == 46, "R6 released for TA and data", oe_rises, 46);
    chk(status == {4'b0001, 2'b10, phy, rg, d}, "R6 read data", status, {4'b0001, 2'b10, phy, rg, d});
  endtask

  task automatic t_invalid(input bit both);
    logic [31:0] w;
    w = mk(both, both, 5'h0A, 5'h15, 16'h1234);
    rises = 0;
    issue(w);
    chk(status == {4'b0001, w[27:0]}, "R9 ready immediate", status, {4'b0001, w[27:0]});
    repeat (4 * HALF) @(negedge clk);
    chk(rises == 0 && !mdc, "R9 no MDC activity", rises, 0);
  endtask

  task automatic t_busy_ignore;
    int n;
    logic [63:0] exp;
    rises = 0;
    issue(mk(0, 1, 5'h03, 5'h09, 16'h5A5A));
    repeat (20 * HALF) @(negedge clk);
    issue(mk(1, 0, 5'h1C, 5'h02, 16'hFFFF));
    chk(status[28:16] == {1'b0, 2'b01, 5'h03, 5'h09}, "R8 fields kept",
        status[28:16], {1'b0, 2'b01, 5'h03, 5'h09});
    wait_ready(n);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h03, 5'h09, 2'b10, 16'h5A5A};
    chk(cap == exp && rises == 64, "R8 frame unaffected", cap, exp);
    chk(status[15:0] == 16'h5A5A, "R8 data kept", status[15:0], 16'h5A5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(5'h1F, 5'h00, 16'hA5C3);
    t_read(5'h01, 5'h05, 16'h8001);
    t_read(5'h10, 5'h1F, 16'h7FFE);
    t_invalid(1'b1);
    t_invalid(1'b0);
    t_busy_ignore();
    t_write(5'h00, 5'h1F, 16'h0000);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule